// File: doc/BRIEF.md
# Packet-Count and Line-Qualified Interrupt Unit

This block produces the host interrupt line of a teletext/VBI data capture front end. It watches two event sources. The first is the fill level of the packet cache: once the number of stored packets reaches a threshold that the host programs, the source fires. The host can also require that this happens only while the video timing reports one chosen line number, so the interrupt lands at a predictable point of the frame. The second source is a one-cycle pulse that marks the end of a DMA transfer.

Each source has an enable bit, a sticky pending flag and a self-mask option. Pending flags are set whatever the enable is, and the host clears them by writing ones. When self-mask is on, the edge that sets a source's pending flag also clears its enable, so the source requests service once and then stays quiet until the host turns it on again. The host configures the block through a small write port with a 2-bit select.

Each source is a two-state machine. `SRC_IDLE` means no event is waiting. `SRC_PEND` means an event has been latched. The transition *fire* (`SRC_IDLE` to `SRC_PEND`) happens on an event. The transition *ack* (`SRC_PEND` to `SRC_IDLE`) happens on a write-one-to-clear when no event arrives in the same cycle. In every other case the state holds.

Top module: `pkt_irq_unit`

## Requirements
- R1: After reset, `irq_o` is 0, both bits of `pend_o` are 0, both bits of `en_o` are 0, and the threshold, target line, self-mask bits and line-qualify bit are all 0.
- R2: A write with `wr_sel`=0 loads the threshold from `wr_data[7:0]`. The count source's event is true in any cycle where the threshold is nonzero and `pkt_count` >= threshold. Its pending flag (`pend_o[0]`) is 1 after the next rising edge. A count of threshold-1 does not set it.
- R3: When the threshold is 0, the count source never sets its pending flag, whatever `pkt_count` is.
- R4: A write with `wr_sel`=1 loads the target line from `wr_data[9:0]`. When the line-qualify bit (`wr_sel`=2, `wr_data[4]`) is 1, the count event is true only in cycles where `line_num` equals the target line.
- R5: A `dma_done` pulse sets the DMA pending flag (`pend_o[1]`) at the next rising edge.
- R6: A pending flag stays 1 until a write with `wr_sel`=3 has a 1 in its bit: `wr_data[0]` clears the count flag and `wr_data[1]` clears the DMA flag. A 0 in that bit leaves the flag unchanged. If a source's event occurs in the same cycle as its clear, the flag stays set.
- R7: A write with `wr_sel`=2 sets the count enable from `wr_data[0]` and the DMA enable from `wr_data[1]`; these are shown on `en_o`. `irq_o` is a register. It is 1 whenever some source has both its pending flag and its enable at 1. A pending flag with its enable at 0 does not raise `irq_o`.
- R8: In the same `wr_sel`=2 write, `wr_data[2]` sets count self-mask and `wr_data[3]` sets DMA self-mask. With self-mask on, the edge that moves a source from `SRC_IDLE` to `SRC_PEND` also clears that source's enable. `irq_o` is 1 for that one cycle, because it uses the enable as it stood before the clear, and then drops.
- R9: A control write that turns on the enable of a source already in `SRC_PEND` raises `irq_o` at the edge of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_count | input | 8 | Number of packets waiting in the cache |
| line_num | input | 10 | Current video line number |
| dma_done | input | 1 | One-cycle pulse at the end of a DMA transfer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 threshold, 1 target line, 2 control, 3 pending clear |
| wr_data | input | 10 | Write data |
| irq_o | output | 1 | Interrupt request, active high |
| pend_o | output | 2 | Pending flags: bit 0 is the count source, bit 1 is DMA |
| en_o | output | 2 | Source enables: bit 0 is the count source, bit 1 is DMA |

## Verification
Each source's state and enable appear directly on `pend_o` and `en_o`. A state machine stuck in, or wrongly leaving, `SRC_PEND` therefore shows on those ports one edge after the stimulus, and `irq_o` misbehaves at that same edge. A wrong threshold, target line or line-qualify bit is not visible on any port until a stimulus lies on one side of the boundary: threshold-1 against threshold, or the target line against a neighbouring line. The tests step across each of those boundaries. Self-mask faults appear within two edges, as `irq_o` either staying high or never rising.

// File: rtl/pkt_irq_pkg.sv
package pkt_irq_pkg;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_t;

    localparam int NUM_SRC = 2;
    localparam int SRC_CNT = 0;
    localparam int SRC_DMA = 1;

    localparam logic [1:0] SEL_THR  = 2'd0;
    localparam logic [1:0] SEL_LINE = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_ACK  = 2'd3;

    localparam int CTRL_EN_LSB = 0;
    localparam int CTRL_SM_LSB = 2;
    localparam int CTRL_LQ     = 4;
    localparam int CTRL_W      = 5;

endpackage

// File: rtl/pkt_irq_cnt_trig.sv
module pkt_irq_cnt_trig #(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 10
) (
    input  logic [CNT_W-1:0]  pkt_count,
    input  logic [CNT_W-1:0]  thr,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] tgt_line,
    input  logic              line_qual,
    output logic              hit
);
    logic thr_on;
    logic level_ok;
    logic line_ok;

    always_comb begin
        thr_on   = (thr != '0);
        level_ok = (pkt_count >= thr);
        line_ok  = !line_qual || (line_num == tgt_line);
        hit      = thr_on && level_ok && line_ok;
    end
endmodule

// File: rtl/pkt_irq_source.sv
module pkt_irq_source
    import pkt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic en_wr,
    input  logic en_wr_val,
    input  logic self_mask,
    output logic pend_o,
    output logic en_o,
    output logic req_nxt
);
    src_state_t state_q, state_d;
    logic       en_q, en_d;
    logic       fire;
    logic       self_clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            SRC_IDLE: begin
                if (evt) begin
                    state_d = SRC_PEND;   // fire
                    fire    = 1'b1;
                end
            end
            SRC_PEND: begin
                if (clr && !evt) begin
                    state_d = SRC_IDLE;   // ack
                end
            end
        endcase
        self_clr = fire && self_mask;
        en_d     = en_wr ? en_wr_val : en_q;
        if (self_clr) begin
            en_d = 1'b0;
        end
        req_nxt = (state_d == SRC_PEND) && (self_clr ? en_q : en_d);
        pend_o  = (state_q == SRC_PEND);
        en_o    = en_q;
    end
endmodule

// File: rtl/pkt_irq_unit.sv
module pkt_irq_unit
    import pkt_irq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       pkt_count,
    input  logic [LINE_W-1:0]      line_num,
    input  logic                   dma_done,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [((LINE_W > CNT_W) ? LINE_W : CNT_W)-1:0] wr_data,
    output logic                   irq_o,
    output logic [NUM_SRC-1:0]     pend_o,
    output logic [NUM_SRC-1:0]     en_o
);
    localparam int DATA_W = (LINE_W > CNT_W) ? LINE_W : CNT_W;

    logic [CNT_W-1:0]   thr_q;
    logic [LINE_W-1:0]  tgt_q;
    logic [NUM_SRC-1:0] sm_q;
    logic               lq_q;
    logic               cnt_hit;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] req_nxt;
    logic               wr_ctrl;
    logic               wr_ack;

    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign wr_ack  = wr_en && (wr_sel == SEL_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
            tgt_q <= '0;
            sm_q  <= '0;
            lq_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_THR:  thr_q <= wr_data[CNT_W-1:0];
                SEL_LINE: tgt_q <= wr_data[LINE_W-1:0];
                SEL_CTRL: begin
                    sm_q <= wr_data[CTRL_SM_LSB +: NUM_SRC];
                    lq_q <= wr_data[CTRL_LQ];
                end
                SEL_ACK:  ;
            endcase
        end
    end

    pkt_irq_cnt_trig #(
        .CNT_W  (CNT_W),
        .LINE_W (LINE_W)
    ) u_trig (
        .pkt_count (pkt_count),
        .thr       (thr_q),
        .line_num  (line_num),
        .tgt_line  (tgt_q),
        .line_qual (lq_q),
        .hit       (cnt_hit)
    );

    assign evt[SRC_CNT] = cnt_hit;
    assign evt[SRC_DMA] = dma_done;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        pkt_irq_source u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt[i]),
            .clr       (wr_ack && wr_data[i]),
            .en_wr     (wr_ctrl),
            .en_wr_val (wr_data[CTRL_EN_LSB + i]),
            .self_mask (sm_q[i]),
            .pend_o    (pend_o[i]),
            .en_o      (en_o[i]),
            .req_nxt   (req_nxt[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |req_nxt;
        end
    end
endmodule

// File: rtl/pkt_irq_unit_chk.sv
module pkt_irq_unit_chk #(
    parameter int DATA_W  = 10,
    parameter int NUM_SRC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_done,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_o,
    input logic [NUM_SRC-1:0] pend_o,
    input logic [NUM_SRC-1:0] en_o,
    input logic [NUM_SRC-1:0] sm_q
);
    logic ack_cnt, ack_dma, ctrl_wr;
    assign ack_cnt = wr_en && (wr_sel == 2'd3) && wr_data[0];
    assign ack_dma = wr_en && (wr_sel == 2'd3) && wr_data[1];
    assign ctrl_wr = wr_en && (wr_sel == 2'd2);

    // R5
    dma_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> pend_o[1]);

    // R6
    cnt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[0] && !ack_cnt) |=> pend_o[0]);

    // R6
    dma_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[1] && !ack_dma) |=> pend_o[1]);

    // R7
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o != '0));

    // R7
    irq_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & en_o) != '0) |-> irq_o);

    // R8
    dma_self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && sm_q[1] && !pend_o[1] && !ctrl_wr) |=> !en_o[1]);
endmodule

bind pkt_irq_unit pkt_irq_unit_chk #(
    .DATA_W  (DATA_W),
    .NUM_SRC (pkt_irq_pkg::NUM_SRC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_done (dma_done),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .irq_o    (irq_o),
    .pend_o   (pend_o),
    .en_o     (en_o),
    .sm_q     (sm_q)
);

// File: tb/sim_pkt_irq_unit.sv
module sim_pkt_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pkt_count = '0;
    logic [9:0] line_num = '0;
    logic       dma_done = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [9:0] wr_data = '0;
    logic       irq_o;
    logic [1:0] pend_o;
    logic [1:0] en_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    pkt_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pkt_count(pkt_count), .line_num(line_num),
        .dma_done(dma_done), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_o(irq_o), .pend_o(pend_o), .en_o(en_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [9:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic dma_pulse();
        dma_done = 1'b1;
        tick();
        dma_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", irq_o, 0);
        chk("R1 pend", pend_o, 0);
        chk("R1 en", en_o, 0);
        pkt_count = 8'd255;
        tick();
        chk("R1 zero threshold after reset", pend_o, 0);
        pkt_count = 0;
    endtask

    task automatic t_threshold();
        wr(2'd0, 10'd5);
        wr(2'd2, 10'h001);
        pkt_count = 8'd4; tick();
        chk("R2 below threshold pend", pend_o[0], 0);
        chk("R2 below threshold irq", irq_o, 0);
        pkt_count = 8'd5; tick();
        chk("R2 at threshold pend", pend_o[0], 1);
        chk("R2 at threshold irq", irq_o, 1);
        pkt_count = 8'd0; tick();
        chk("R6 sticky after count drops", pend_o[0], 1);
        wr(2'd3, 10'h001);
        chk("R6 w1c clears", pend_o[0], 0);
        chk("R6 irq drops on clear", irq_o, 0);
        pkt_count = 8'd200; tick();
        chk("R2 above threshold", pend_o[0], 1);
        pkt_count = 0;
        wr(2'd3, 10'h001);
    endtask

    task automatic t_sticky();
        wr(2'd0, 10'd5);
        pkt_count = 8'd5; tick();
        wr(2'd3, 10'h001);
        chk("R6 event beats clear", pend_o[0], 1);
        pkt_count = 0;
        wr(2'd3, 10'h002);
        chk("R6 zero bit leaves flag", pend_o[0], 1);
        wr(2'd0, 10'h001);
        chk("R6 other register write leaves flag", pend_o[0], 1);
        wr(2'd3, 10'h001);
        chk("R6 cleared", pend_o[0], 0);
    endtask

    task automatic t_zero_thr();
        wr(2'd0, 10'd0);
        pkt_count = 8'd255; tick();
        chk("R3 threshold 0 max count", pend_o[0], 0);
        pkt_count = 8'd0; tick();
        chk("R3 threshold 0 zero count", pend_o[0], 0);
        chk("R3 no irq", irq_o, 0);
    endtask

    task automatic t_line();
        wr(2'd1, 10'd100);
        wr(2'd0, 10'd3);
        wr(2'd2, 10'h011);
        pkt_count = 8'd10; line_num = 10'd99; tick();
        chk("R4 wrong line", pend_o[0], 0);
        line_num = 10'd101; tick();
        chk("R4 next line", pend_o[0], 0);
        pkt_count = 8'd2; line_num = 10'd100; tick();
        chk("R4 line ok count low", pend_o[0], 0);
        pkt_count = 8'd3; tick();
        chk("R4 line match", pend_o[0], 1);
        chk("R4 irq", irq_o, 1);
        pkt_count = 0; line_num = 0;
        wr(2'd3, 10'h001);
        wr(2'd2, 10'h000);
    endtask

    task automatic t_dma();
        wr(2'd2, 10'h002);
        chk("R7 dma enable shown", en_o, 2);
        dma_pulse();
        chk("R5 dma pend", pend_o[1], 1);
        chk("R5 dma irq", irq_o, 1);
        tick();
        chk("R6 dma sticky", pend_o[1], 1);
        wr(2'd3, 10'h002);
        chk("R6 dma clear", pend_o[1], 0);
        chk("R7 irq low after clear", irq_o, 0);
    endtask

    task automatic t_mask();
        wr(2'd2, 10'h000);
        dma_pulse();
        chk("R7 masked pend", pend_o[1], 1);
        chk("R7 masked irq", irq_o, 0);
        wr(2'd2, 10'h002);
        chk("R9 enable raises irq", irq_o, 1);
        wr(2'd3, 10'h002);
        chk("R7 clear", irq_o, 0);
    endtask

    task automatic t_self_mask();
        wr(2'd2, 10'h00A);
        dma_pulse();
        chk("R8 dma pend", pend_o[1], 1);
        chk("R8 dma enable cleared", en_o[1], 0);
        chk("R8 irq one cycle", irq_o, 1);
        tick();
        chk("R8 irq dropped", irq_o, 0);
        chk("R8 still pend", pend_o[1], 1);
        wr(2'd3, 10'h002);
        dma_pulse();
        chk("R8 later event pend", pend_o[1], 1);
        chk("R8 later event no irq", irq_o, 0);
        wr(2'd3, 10'h002);
        wr(2'd0, 10'd1);
        wr(2'd2, 10'h005);
        pkt_count = 8'd1; tick();
        chk("R8 count enable cleared", en_o[0], 0);
        chk("R8 count irq pulse", irq_o, 1);
        tick();
        chk("R8 count irq dropped", irq_o, 0);
        pkt_count = 0;
        wr(2'd3, 10'h003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_sticky();
        t_zero_thr();
        t_line();
        t_dma();
        t_mask();
        t_self_mask();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule